// File: doc/BRIEF.md
# NAND Flash Program/Erase Sequencer

This block sits on the host side of a raw 8-bit NAND flash bus and turns a single user request into a complete write-type transaction. A request names the operation (page program or block erase) and a column and row address. For a program, the page contents arrive as a byte stream with a valid/ready handshake. The sequencer places each byte on the bus in a bus cycle of its own. In each cycle it holds the chip enable, the command-latch and address-latch strobes and the output data steady around a write-enable pulse.

Each operation is a two-command transaction. A setup command is followed by the address cycles (and, for a program, the data cycles), and a confirm command then starts the internal operation. The controller next waits for the ready/busy line to fall and then rise again. It issues the status-read command, performs one read-enable cycle and reports the result with a one-cycle done pulse and a fail flag. A watchdog on the busy wait drops the transaction if the device never falls busy or never recovers. All pulse widths come from parameters counted in clock cycles. The device handles program/verify retries internally, so the controller has no retry logic.

Top module: `nand_pe_sequencer`

## Requirements
- R1: After reset, nand_ce_n, nand_we_n and nand_re_n are high, nand_cle, nand_ale, nand_io_oe, done, fail and timeout are low, req_ready is high and dat_ready is low.
- R2: A program request (req_erase=0) produces, in this order, one command cycle 0x80, address cycles carrying req_col then req_row[7:0] then req_row[15:8], PAGE_BYTES data cycles with the streamed bytes in arrival order, and one command cycle 0x10. A command cycle has nand_cle=1 and nand_ale=0, an address cycle has nand_ale=1 and nand_cle=0, and a data cycle has both low.
- R3: An erase request (req_erase=1) produces exactly one command cycle 0x60, two address cycles req_row[7:0] then req_row[15:8], and one command cycle 0xD0, with no other cycle between them.
- R4: nand_we_n stays low for exactly T_LOW clock cycles per bus cycle. nand_cle, nand_ale and nand_io_out do not change from the cycle in which nand_we_n falls through the cycle in which it rises, and nand_cle and nand_ale are never high together.
- R5: After the confirm command the controller waits for nand_rb to go low and then high. Only then does it send command 0x70 and perform exactly one read cycle with nand_re_n low for T_LOW cycles. nand_io_oe is low while nand_re_n is low.
- R6: done is a one-cycle pulse at the end of each accepted request. fail equals bit 0 of the status byte read from nand_io_in (set means failed) and holds its value until the next request is accepted.
- R7: If nand_rb does not reach the awaited level within BUSY_LIMIT cycles of a wait, the controller raises timeout and fail together with done, sends no 0x70 and returns to idle. A rise of nand_rb observed in the cycle the limit is reached counts as ready.
- R8: req_ready is high only while idle and drops the cycle after a request is accepted. dat_ready is high only while the controller waits for the next data byte. A pause in dat_valid delays the data cycles without adding, dropping or reordering any bus cycle.
- R9: nand_ce_n is low whenever nand_we_n or nand_re_n is low and is high again when done pulses. nand_we_n and nand_re_n are never low together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe |
| req_ready | output | 1 | Controller idle and able to take a request |
| req_erase | input | 1 | 1 selects block erase, 0 selects page program |
| req_col | input | COL_CYCLES*8 | Column address |
| req_row | input | ROW_CYCLES*8 | Row (page/block) address, low byte sent first |
| dat_valid | input | 1 | Program data byte available |
| dat_ready | output | 1 | Controller takes the offered data byte |
| dat_byte | input | 8 | Program data byte |
| nand_ce_n | output | 1 | Chip enable, active low |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_we_n | output | 1 | Write enable, active low |
| nand_re_n | output | 1 | Read enable, active low |
| nand_io_out | output | 8 | Byte driven onto the I/O bus |
| nand_io_oe | output | 1 | I/O bus output enable |
| nand_io_in | input | 8 | Byte read from the I/O bus |
| nand_rb | input | 1 | Ready (1) / busy (0) from the device |
| done | output | 1 | One-cycle completion pulse |
| fail | output | 1 | Operation failed or timed out |
| timeout | output | 1 | Busy wait exceeded BUSY_LIMIT |

## Verification
The return of ready and the expiry of the busy watchdog can land in the same cycle. When they do, the rule is that an observed ready wins. The bench provokes the collision by sweeping the device model's busy duration one cycle at a time across the watchdog limit. For every step it judges consistency at the ports: a timed-out operation must show timeout and fail together and no status command on the bus, and a completed one must show exactly one status read. Once a step has timed out, no longer busy duration may complete, and the far ends of the sweep must land on opposite sides.

// File: rtl/nand_seq_pkg.sv
package nand_seq_pkg;

  localparam logic [7:0] CMD_PROG_SETUP  = 8'h80;
  localparam logic [7:0] CMD_PROG_GO     = 8'h10;
  localparam logic [7:0] CMD_ERASE_SETUP = 8'h60;
  localparam logic [7:0] CMD_ERASE_GO    = 8'hD0;
  localparam logic [7:0] CMD_STATUS      = 8'h70;

  typedef enum logic [1:0] {
    CYC_CMD  = 2'd0,
    CYC_ADDR = 2'd1,
    CYC_DATA = 2'd2,
    CYC_READ = 2'd3
  } cyc_kind_e;

  typedef struct packed {
    cyc_kind_e  kind;
    logic [7:0] val;
  } cyc_req_t;

endpackage

// File: rtl/nand_rb_sync.sv
module nand_rb_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic rb_async,
  output logic rb_sync
);

  logic [STAGES-1:0] sh;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) sh <= 1'b1;
        else     sh <= rb_async;
      end
    end else begin : g_chain
      always_ff @(posedge clk) begin
        if (rst) sh <= '1;
        else     sh <= {sh[STAGES-2:0], rb_async};
      end
    end
  endgenerate

  assign rb_sync = sh[STAGES-1];

endmodule

// File: rtl/nand_busy_watch.sv
module nand_busy_watch #(
  parameter int BUSY_LIMIT = 1000
) (
  input  logic clk,
  input  logic rst,
  input  logic clear,
  input  logic run,
  output logic expired
);

  localparam int CW = $clog2(BUSY_LIMIT + 1);
  localparam logic [CW-1:0] LAST = CW'(BUSY_LIMIT - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)        cnt <= '0;
    else if (clear) cnt <= '0;
    else if (run && cnt != LAST) cnt <= cnt + 1'b1;
  end

  assign expired = run && (cnt == LAST);

endmodule

// File: rtl/nand_cycle_engine.sv
module nand_cycle_engine
  import nand_seq_pkg::*;
#(
  parameter int T_SETUP = 2,
  parameter int T_LOW   = 3,
  parameter int T_HOLD  = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       start,
  input  cyc_req_t   req,
  output logic       fin,
  output logic       we_n,
  output logic       re_n,
  output logic       cle,
  output logic       ale,
  output logic [7:0] io_out,
  output logic       io_oe,
  input  logic [7:0] io_in,
  output logic [7:0] rd_val
);

  localparam int TA   = (T_SETUP > T_LOW) ? T_SETUP : T_LOW;
  localparam int TMAX = (TA > T_HOLD) ? TA : T_HOLD;
  localparam int CW   = $clog2(TMAX + 1);

  typedef enum logic [1:0] {PH_IDLE, PH_SETUP, PH_LOW, PH_HOLD} phase_e;

  phase_e        ph;
  logic [CW-1:0] cnt;
  logic          is_rd;

  always_ff @(posedge clk) begin
    if (rst) begin
      ph     <= PH_IDLE;
      cnt    <= '0;
      is_rd  <= 1'b0;
      fin    <= 1'b0;
      we_n   <= 1'b1;
      re_n   <= 1'b1;
      cle    <= 1'b0;
      ale    <= 1'b0;
      io_out <= '0;
      io_oe  <= 1'b0;
      rd_val <= '0;
    end else begin
      fin <= 1'b0;
      case (ph)
        PH_IDLE: begin
          if (start) begin
            cle    <= (req.kind == CYC_CMD);
            ale    <= (req.kind == CYC_ADDR);
            io_out <= (req.kind == CYC_READ) ? 8'h00 : req.val;
            io_oe  <= (req.kind != CYC_READ);
            is_rd  <= (req.kind == CYC_READ);
            cnt    <= CW'(T_SETUP - 1);
            ph     <= PH_SETUP;
          end
        end
        PH_SETUP: begin
          if (cnt == '0) begin
            if (is_rd) re_n <= 1'b0;
            else       we_n <= 1'b0;
            cnt <= CW'(T_LOW - 1);
            ph  <= PH_LOW;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        PH_LOW: begin
          if (cnt == '0) begin
            we_n <= 1'b1;
            re_n <= 1'b1;
            if (is_rd) rd_val <= io_in;
            cnt <= CW'(T_HOLD - 1);
            ph  <= PH_HOLD;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        default: begin
          if (cnt == '0) begin
            cle   <= 1'b0;
            ale   <= 1'b0;
            io_oe <= 1'b0;
            fin   <= 1'b1;
            ph    <= PH_IDLE;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
      endcase
    end
  end

endmodule

// File: rtl/nand_pe_sequencer.sv
module nand_pe_sequencer
  import nand_seq_pkg::*;
#(
  parameter int         PAGE_BYTES  = 528,
  parameter int         COL_CYCLES  = 1,
  parameter int         ROW_CYCLES  = 2,
  parameter int         T_SETUP     = 2,
  parameter int         T_LOW       = 3,
  parameter int         T_HOLD      = 2,
  parameter int         BUSY_LIMIT  = 2000000,
  parameter int         SYNC_STAGES = 2,
  parameter logic [7:0] FAIL_MASK   = 8'h01
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    req_valid,
  output logic                    req_ready,
  input  logic                    req_erase,
  input  logic [COL_CYCLES*8-1:0] req_col,
  input  logic [ROW_CYCLES*8-1:0] req_row,
  input  logic                    dat_valid,
  output logic                    dat_ready,
  input  logic [7:0]              dat_byte,
  output logic                    nand_ce_n,
  output logic                    nand_cle,
  output logic                    nand_ale,
  output logic                    nand_we_n,
  output logic                    nand_re_n,
  output logic [7:0]              nand_io_out,
  output logic                    nand_io_oe,
  input  logic [7:0]              nand_io_in,
  input  logic                    nand_rb,
  output logic                    done,
  output logic                    fail,
  output logic                    timeout
);

  localparam int ADDR_CYCLES = COL_CYCLES + ROW_CYCLES;
  localparam int AW = $clog2(ADDR_CYCLES + 1);
  localparam int DW = $clog2(PAGE_BYTES + 1);
  localparam logic [AW-1:0] A_LAST     = AW'(ADDR_CYCLES - 1);
  localparam logic [AW-1:0] A_ROW_BASE = AW'(COL_CYCLES);
  localparam logic [DW-1:0] D_LAST     = DW'(PAGE_BYTES - 1);

  typedef enum logic [3:0] {
    S_IDLE, S_OPEN, S_ADDR, S_DATA, S_CONFIRM,
    S_WAIT_LO, S_WAIT_HI, S_STAT_CMD, S_STAT_RD
  } seq_state_e;

  seq_state_e              st;
  logic                    issued;
  logic                    erase_q;
  logic [ADDR_CYCLES*8-1:0] addr_q;
  logic [AW-1:0]           aidx;
  logic [DW-1:0]           dcnt;

  logic       in_bus, issue;
  cyc_req_t   cyc;
  logic       eng_fin;
  logic [7:0] eng_rd;
  logic       rb_s;
  logic       wd_clear, wd_run, wd_expired;

  nand_rb_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .rb_async(nand_rb), .rb_sync(rb_s)
  );

  nand_busy_watch #(.BUSY_LIMIT(BUSY_LIMIT)) u_watch (
    .clk(clk), .rst(rst), .clear(wd_clear), .run(wd_run), .expired(wd_expired)
  );

  nand_cycle_engine #(.T_SETUP(T_SETUP), .T_LOW(T_LOW), .T_HOLD(T_HOLD)) u_eng (
    .clk(clk), .rst(rst), .start(issue), .req(cyc), .fin(eng_fin),
    .we_n(nand_we_n), .re_n(nand_re_n), .cle(nand_cle), .ale(nand_ale),
    .io_out(nand_io_out), .io_oe(nand_io_oe), .io_in(nand_io_in), .rd_val(eng_rd)
  );

  always_comb begin
    in_bus = (st == S_OPEN) || (st == S_ADDR) || (st == S_DATA) ||
             (st == S_CONFIRM) || (st == S_STAT_CMD) || (st == S_STAT_RD);
    issue  = in_bus && !issued && ((st != S_DATA) || dat_valid);
    cyc.kind = CYC_CMD;
    cyc.val  = 8'h00;
    case (st)
      S_OPEN:     cyc.val = erase_q ? CMD_ERASE_SETUP : CMD_PROG_SETUP;
      S_ADDR: begin
        cyc.kind = CYC_ADDR;
        cyc.val  = addr_q[aidx*8 +: 8];
      end
      S_DATA: begin
        cyc.kind = CYC_DATA;
        cyc.val  = dat_byte;
      end
      S_CONFIRM:  cyc.val = erase_q ? CMD_ERASE_GO : CMD_PROG_GO;
      S_STAT_CMD: cyc.val = CMD_STATUS;
      S_STAT_RD:  cyc.kind = CYC_READ;
      default:    cyc.val = 8'h00;
    endcase
  end

  assign req_ready = (st == S_IDLE);
  assign dat_ready = (st == S_DATA) && !issued;
  assign wd_run    = (st == S_WAIT_LO) || (st == S_WAIT_HI);
  assign wd_clear  = ((st == S_CONFIRM) && eng_fin) || ((st == S_WAIT_LO) && !rb_s);

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= S_IDLE;
      issued    <= 1'b0;
      erase_q   <= 1'b0;
      addr_q    <= '0;
      aidx      <= '0;
      dcnt      <= '0;
      nand_ce_n <= 1'b1;
      done      <= 1'b0;
      fail      <= 1'b0;
      timeout   <= 1'b0;
    end else begin
      done <= 1'b0;
      if (issue)        issued <= 1'b1;
      else if (eng_fin) issued <= 1'b0;

      case (st)
        S_IDLE: begin
          if (req_valid) begin
            erase_q   <= req_erase;
            addr_q    <= {req_row, req_col};
            fail      <= 1'b0;
            timeout   <= 1'b0;
            nand_ce_n <= 1'b0;
            st        <= S_OPEN;
          end
        end
        S_OPEN: begin
          if (eng_fin) begin
            aidx <= erase_q ? A_ROW_BASE : '0;
            st   <= S_ADDR;
          end
        end
        S_ADDR: begin
          if (eng_fin) begin
            if (aidx == A_LAST) begin
              dcnt <= '0;
              st   <= erase_q ? S_CONFIRM : S_DATA;
            end else begin
              aidx <= aidx + 1'b1;
            end
          end
        end
        S_DATA: begin
          if (eng_fin) begin
            if (dcnt == D_LAST) st <= S_CONFIRM;
            else                dcnt <= dcnt + 1'b1;
          end
        end
        S_CONFIRM: begin
          if (eng_fin) st <= S_WAIT_LO;
        end
        S_WAIT_LO: begin
          if (!rb_s) begin
            st <= S_WAIT_HI;
          end else if (wd_expired) begin
            timeout   <= 1'b1;
            fail      <= 1'b1;
            done      <= 1'b1;
            nand_ce_n <= 1'b1;
            st        <= S_IDLE;
          end
        end
        S_WAIT_HI: begin
          if (rb_s) begin
            st <= S_STAT_CMD;
          end else if (wd_expired) begin
            timeout   <= 1'b1;
            fail      <= 1'b1;
            done      <= 1'b1;
            nand_ce_n <= 1'b1;
            st        <= S_IDLE;
          end
        end
        S_STAT_CMD: begin
          if (eng_fin) st <= S_STAT_RD;
        end
        S_STAT_RD: begin
          if (eng_fin) begin
            fail      <= |(eng_rd & FAIL_MASK);
            done      <= 1'b1;
            nand_ce_n <= 1'b1;
            st        <= S_IDLE;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/nand_pe_sequencer_chk.sv
module nand_pe_sequencer_chk (
  input logic       clk,
  input logic       rst,
  input logic       req_valid,
  input logic       req_ready,
  input logic       dat_ready,
  input logic       nand_ce_n,
  input logic       nand_cle,
  input logic       nand_ale,
  input logic       nand_we_n,
  input logic       nand_re_n,
  input logic [7:0] nand_io_out,
  input logic       nand_io_oe,
  input logic       done,
  input logic       fail,
  input logic       timeout
);

  a_r4_latch_excl: assert property (@(posedge clk) disable iff (rst)
    !(nand_cle && nand_ale));

  a_r4_setup_stable: assert property (@(posedge clk) disable iff (rst)
    $fell(nand_we_n) |-> ($stable(nand_io_out) && $stable(nand_cle) && $stable(nand_ale)));

  a_r4_low_stable: assert property (@(posedge clk) disable iff (rst)
    !$past(nand_we_n) |-> ($stable(nand_io_out) && $stable(nand_cle) && $stable(nand_ale)));

  a_r5_no_drive_on_read: assert property (@(posedge clk) disable iff (rst)
    !nand_re_n |-> !nand_io_oe);

  a_r6_done_pulse: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  a_r7_timeout_fails: assert property (@(posedge clk) disable iff (rst)
    timeout |-> fail);

  a_r8_ready_drops: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> !req_ready);

  a_r8_data_not_idle: assert property (@(posedge clk) disable iff (rst)
    dat_ready |-> !req_ready);

  a_r9_strobe_in_ce: assert property (@(posedge clk) disable iff (rst)
    (!nand_we_n || !nand_re_n) |-> !nand_ce_n);

  a_r9_we_re_excl: assert property (@(posedge clk) disable iff (rst)
    !(!nand_we_n && !nand_re_n));

endmodule

bind nand_pe_sequencer nand_pe_sequencer_chk u_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
  .dat_ready(dat_ready), .nand_ce_n(nand_ce_n), .nand_cle(nand_cle),
  .nand_ale(nand_ale), .nand_we_n(nand_we_n), .nand_re_n(nand_re_n),
  .nand_io_out(nand_io_out), .nand_io_oe(nand_io_oe), .done(done),
  .fail(fail), .timeout(timeout)
);

// File: tb/nand_pe_sequencer_test.sv
module nand_pe_sequencer_test;

  localparam int PB  = 16;
  localparam int TS  = 1;
  localparam int TL  = 2;
  localparam int TH  = 1;
  localparam int LIM = 120;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       req_valid = 1'b0, req_erase = 1'b0;
  logic [7:0] req_col = '0;
  logic [15:0] req_row = '0;
  logic       dat_valid = 1'b0;
  logic [7:0] dat_byte = '0;
  logic       req_ready, dat_ready;
  logic       nand_ce_n, nand_cle, nand_ale, nand_we_n, nand_re_n, nand_io_oe;
  logic [7:0] nand_io_out, nand_io_in;
  logic       nand_rb = 1'b1;
  logic       done, fail, timeout;

  always #2 clk = ~clk;

  nand_pe_sequencer #(
    .PAGE_BYTES(PB), .T_SETUP(TS), .T_LOW(TL), .T_HOLD(TH), .BUSY_LIMIT(LIM)
  ) uut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_erase(req_erase), .req_col(req_col), .req_row(req_row),
    .dat_valid(dat_valid), .dat_ready(dat_ready), .dat_byte(dat_byte),
    .nand_ce_n(nand_ce_n), .nand_cle(nand_cle), .nand_ale(nand_ale),
    .nand_we_n(nand_we_n), .nand_re_n(nand_re_n), .nand_io_out(nand_io_out),
    .nand_io_oe(nand_io_oe), .nand_io_in(nand_io_in), .nand_rb(nand_rb),
    .done(done), .fail(fail), .timeout(timeout)
  );

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wrap_up();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL R7 watchdog expired actual=running expected=finished");
    wrap_up();
  end

  // ---------------- device model and bus monitor ----------------
  int  lg_k [0:63];
  int  lg_v [0:63];
  int  lg_n = 0;
  int  busy_len = 30;
  bit  stuck = 0, nobusy = 0, st_fail_bit = 0, stat_mode = 0;
  int  busy_rem = 0;
  int  rd_cnt = 0, e_width = 0, e_stab = 0, e_excl = 0, e_ce = 0, e_oe = 0, e_stat = 0, e_rdy = 0;
  bit  prev_we = 1, prev_re = 1;
  int  we_lo = 0, re_lo = 0;
  logic [9:0] at_fall;

  assign nand_io_in = stat_mode ? (8'hE0 | {7'd0, st_fail_bit}) : 8'h00;

  always @(negedge clk) begin
    bit go_busy;
    go_busy = 0;
    if (nand_cle && nand_ale) e_excl++;
    if ((!nand_we_n || !nand_re_n) && nand_ce_n) e_ce++;
    if (!nand_we_n && !nand_re_n) e_ce++;
    if (!nand_re_n && nand_io_oe) e_oe++;
    if (dat_ready && req_ready) e_rdy++;
    if (!nand_we_n) begin
      if (prev_we) at_fall = {nand_cle, nand_ale, nand_io_out};
      else if (at_fall != {nand_cle, nand_ale, nand_io_out}) e_stab++;
      we_lo++;
    end else if (!prev_we) begin
      if (we_lo != TL) e_width++;
      if (at_fall != {nand_cle, nand_ale, nand_io_out}) e_stab++;
      we_lo = 0;
      if (lg_n < 64) begin
        lg_k[lg_n] = nand_cle ? 0 : (nand_ale ? 1 : 2);
        lg_v[lg_n] = nand_io_out;
        lg_n++;
      end
      if (nand_cle) begin
        stat_mode = (nand_io_out == 8'h70);
        if (nand_io_out == 8'h70 && !nand_rb) e_stat++;
        if ((nand_io_out == 8'h10 || nand_io_out == 8'hD0) && !nobusy) go_busy = 1;
      end
    end
    if (!nand_re_n) re_lo++;
    else if (!prev_re) begin
      if (re_lo != TL) e_width++;
      re_lo = 0;
      rd_cnt++;
    end
    prev_we = nand_we_n;
    prev_re = nand_re_n;
    if (go_busy) begin
      nand_rb = 0;
      busy_rem = busy_len;
    end else if (!nand_rb && !stuck) begin
      if (busy_rem <= 1) nand_rb = 1;
      else busy_rem--;
    end
  end

  // ---------------- one operation ----------------
  task automatic run_op(input bit er, input logic [7:0] col, input logic [15:0] row,
                        input logic [7:0] seed, input int gap, input bit sfail,
                        input int exp_tmo, output bit got_tmo);
    int ex_k [0:63];
    int ex_v [0:63];
    int ex_n, mism, cyc;
    bit got_fail, ce_ok, rdy_ok;
    lg_n = 0; rd_cnt = 0; e_width = 0; e_stab = 0; e_excl = 0;
    e_ce = 0; e_oe = 0; e_stat = 0; e_rdy = 0;
    st_fail_bit = sfail;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1; req_erase = er; req_col = col; req_row = row;
    @(negedge clk);
    req_valid = 0;
    chk(!req_ready, "R8 req_ready after accept", req_ready, 0);
    fork
      begin
        if (!er) begin
          for (int i = 0; i < PB; i++) begin
            dat_valid = 0;
            repeat (gap) @(negedge clk);
            dat_valid = 1;
            dat_byte  = 8'(seed + i * 37);
            while (!dat_ready) @(negedge clk);
            @(negedge clk);
          end
          dat_valid = 0;
        end
      end
      begin
        cyc = 0;
        while (!done && cyc < 20000) begin
          @(negedge clk);
          cyc++;
          if (!done && req_ready) e_rdy++;
        end
      end
    join
    got_fail = fail; got_tmo = timeout; ce_ok = nand_ce_n; rdy_ok = req_ready;
    chk(done == 1, "R6 done seen", done, 1);
    chk(ce_ok == 1, "R9 ce_n high at done", ce_ok, 1);
    chk(rdy_ok == 1, "R8 idle at done", rdy_ok, 1);
    @(negedge clk);
    chk(done == 0, "R6 done one cycle", done, 0);
    repeat (3) @(negedge clk);
    chk(fail == got_fail, "R6 fail held", fail, got_fail);

    ex_n = 0;
    ex_k[ex_n] = 0; ex_v[ex_n] = er ? 8'h60 : 8'h80; ex_n++;
    if (!er) begin ex_k[ex_n] = 1; ex_v[ex_n] = col; ex_n++; end
    ex_k[ex_n] = 1; ex_v[ex_n] = row[7:0];  ex_n++;
    ex_k[ex_n] = 1; ex_v[ex_n] = row[15:8]; ex_n++;
    if (!er) for (int i = 0; i < PB; i++) begin
      ex_k[ex_n] = 2; ex_v[ex_n] = (seed + i * 37) & 8'hFF; ex_n++;
    end
    ex_k[ex_n] = 0; ex_v[ex_n] = er ? 8'hD0 : 8'h10; ex_n++;
    if (!got_tmo) begin ex_k[ex_n] = 0; ex_v[ex_n] = 8'h70; ex_n++; end
    mism = (lg_n != ex_n) ? 1 : 0;
    for (int i = 0; i < ex_n && i < lg_n; i++)
      if (lg_k[i] != ex_k[i] || lg_v[i] != ex_v[i]) mism++;
    if (er) chk(mism == 0, "R3 erase cycle sequence", mism, 0);
    else    chk(mism == 0, "R2 program cycle sequence", mism, 0);

    chk(e_width == 0, "R4 strobe low width", e_width, 0);
    chk(e_stab == 0, "R4 latch/data stable", e_stab, 0);
    chk(e_excl == 0, "R4 cle/ale exclusive", e_excl, 0);
    chk(rd_cnt == (got_tmo ? 0 : 1), "R5 status read count", rd_cnt, got_tmo ? 0 : 1);
    chk(e_oe == 0, "R5 io_oe low in read", e_oe, 0);
    chk(e_stat == 0, "R5 status after ready", e_stat, 0);
    chk(got_fail == (got_tmo ? 1'b1 : sfail), "R6 fail flag", got_fail, got_tmo ? 1 : sfail);
    if (exp_tmo >= 0) chk(got_tmo == exp_tmo[0], "R7 timeout flag", got_tmo, exp_tmo);
    chk(e_rdy == 0, "R8 ready signalling", e_rdy, 0);
    chk(e_ce == 0, "R9 ce and strobe rules", e_ce, 0);
  endtask

  // ---------------- main sequence ----------------
  initial begin
    bit t, prev_t;
    repeat (4) @(negedge clk);
    chk(nand_ce_n && nand_we_n && nand_re_n, "R1 strobes idle in reset",
        {nand_ce_n, nand_we_n, nand_re_n}, 7);
    rst = 0;
    @(negedge clk);
    chk(!nand_cle && !nand_ale && !nand_io_oe, "R1 latches off", {nand_cle, nand_ale, nand_io_oe}, 0);
    chk(!done && !fail && !timeout, "R1 flags clear", {done, fail, timeout}, 0);
    chk(req_ready && !dat_ready, "R1 handshakes", {req_ready, dat_ready}, 2);

    busy_len = 25;
    run_op(0, 8'h12, 16'hA55A, 8'h03, 0, 0, 0, t);
    run_op(0, 8'hFF, 16'h0001, 8'hF0, 3, 1, 0, t);  // R8 stalled stream, failing status
    run_op(1, 8'h00, 16'h3C7E, 8'h00, 0, 0, 0, t);
    run_op(1, 8'h00, 16'hFFFF, 8'h00, 0, 1, 0, t);
    run_op(0, 8'h00, 16'h0000, 8'h77, 1, 0, 0, t);

    // R7: device never goes busy
    nobusy = 1;
    run_op(1, 8'h00, 16'h1234, 8'h00, 0, 0, 1, t);
    nobusy = 0;
    // R7: device stays busy
    stuck = 1;
    run_op(0, 8'h40, 16'h4321, 8'h11, 0, 0, 1, t);
    stuck = 0;
    repeat (5) @(negedge clk);
    run_op(1, 8'h00, 16'h0F0F, 8'h00, 0, 0, 0, t);

    // R7: ready versus watchdog expiry swept across the boundary
    prev_t = 0;
    for (int b = LIM - 12; b <= LIM + 12; b++) begin
      busy_len = b;
      run_op(1, 8'h00, 16'(b), 8'h00, 0, 0, -1, t);
      if (b == LIM - 12) chk(t == 0, "R7 short busy completes", t, 0);
      if (b == LIM + 12) chk(t == 1, "R7 long busy times out", t, 1);
      chk(!(prev_t && !t), "R7 boundary monotonic", t, 1);
      prev_t = t;
      repeat (b + 4) @(negedge clk);
    end

    wrap_up();
  end

endmodule